// File: doc/BRIEF.md
# Internal Access Show-Cycle Mirror

This block sits beside an internal core bus and replays each internal access onto an external bus as a show cycle, so that an emulator or debug probe can follow what the core is doing. Every mirrored access gets a one-clock address phase. A data access also gets a one-clock data phase immediately after it. Neither phase waits for a transfer acknowledge. When the core performs a burst, only its first beat is mirrored. The remaining beats are accepted and discarded.

Each address phase carries a four-bit access-type code. That code tells apart core and DMA accesses, supervisor and user mode, instruction and data fetches, and a trace/reservation marker. Two active-low indicator pins decode the marker directly: one for program trace and one for reservation. Up to two pending accesses wait in a small queue. When that queue is full, the core side is held off through a ready signal.

External outputs are enabled only while a phase is being shown. At all other times they rest at fixed idle values.

Top module: `showcyc_mirror`

## Requirements
- R1: A data access (type bit 2 = 1) is shown as an address phase followed in the very next clock by a data phase. An instruction access (type bit 2 = 0) is shown with an address phase only and no data phase.
- R2: An access accepted at rising edge k on an idle mirror is shown during the clock after edge k+1. In that clock, extAddrOe is 1, extStartN is 0, and extAddr, extType and extWrite are valid. This lasts exactly one clock.
- R3: The data phase lasts exactly one clock, with extDataOe = 1 and extData valid. It ends without any acknowledge input.
- R4: A request with coreBurst = 1 is mirrored once. The next BURST_BEATS-1 accepted requests are its remaining beats: they are accepted with coreRdy = 1 and produce no show cycle.
- R5: extWrite shows the access direction (1 = write) in both phases. The data phase shows coreData as captured at acceptance, for reads and for writes alike.
- R6: Type code bit 0 is 1 for DMA and 0 for core. For core accesses, bit 1 is supervisor, bit 2 is 0 for instruction and 1 for data, and bit 3 is the inverted trace qualifier on instruction accesses or the inverted reservation qualifier on data accesses. For DMA accesses, bits 3:1 equal dmaTypeCfg[2:0] and the core qualifiers are ignored.
- R7: During an address phase, traceN is 0 only if the type code has bits 0, 2 and 3 all 0. resvN is 0 only if bits 0 and 3 are 0 and bit 2 is 1. Both pins are 1 for DMA accesses and outside address phases.
- R8: Pending accesses wait in a two-entry queue and are shown in acceptance order. coreRdy is 0 while the queue is full, except while burst beats are being discarded.
- R9: Outside a phase, extAddrOe and extDataOe are 0 and extStartN is 1. extAddr, extData, extType and extWrite are 0, and both indicator pins are 1.
- R10: While rstN is low, and after it rises, the mirror is idle with coreRdy = 1. Any pending or in-flight access is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| coreReq | input | 1 | Internal access request valid |
| coreRdy | output | 1 | Request accepted when high together with coreReq |
| coreAddr | input | ADDR_W | Access address |
| coreData | input | DATA_W | Write data, or read data returned internally |
| coreWrite | input | 1 | 1 = write, 0 = read |
| coreBurst | input | 1 | Marks the first beat of a burst |
| coreSuper | input | 1 | Supervisor mode qualifier |
| coreInstr | input | 1 | Instruction access qualifier |
| coreTrace | input | 1 | Program-trace qualifier (instruction accesses) |
| coreResv | input | 1 | Reservation qualifier (data accesses) |
| coreDma | input | 1 | Access initiated by DMA |
| dmaTypeCfg | input | 3 | Programmed type bits 3:1 for DMA accesses |
| extAddr | output | ADDR_W | External show address |
| extAddrOe | output | 1 | Output enable for address, type and start |
| extData | output | DATA_W | External show data |
| extDataOe | output | 1 | Output enable for data |
| extStartN | output | 1 | Active-low transfer start |
| extWrite | output | 1 | Direction of the shown access |
| extType | output | 4 | Access-type code |
| traceN | output | 1 | Active-low program-trace indicator |
| resvN | output | 1 | Active-low reservation indicator |

## Verification
Several rules are checked by assertions on every clock: each address and data phase lasts a single clock, a data phase only follows the address phase of a data access, the indicator pins agree with the type code and are never low together or for DMA, idle outputs stay at their rest values, and the queue never overflows or underflows. Other behaviour can only be shown by the bench's scenarios. Those scenarios cover the exact type code produced for each combination of qualifiers, the latency from acceptance to the address phase, the discarding of later burst beats, the queue back-pressure and ordering under a stream of requests, and the clearing of an in-flight access by reset.

// File: rtl/showPkg.sv
package showPkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  typedef struct packed {
    logic push;      // store accepted access in queue
    logic pop;       // take head, start address phase
    logic showData;  // start data phase of held access
  } ctrlStrobe_t;

  // Build the four-bit access-type code {bit3,bit2,bit1,bit0}
  function automatic logic [3:0] encType(input logic dma, input logic sup,
                                         input logic instr, input logic trace,
                                         input logic resv,
                                         input logic [2:0] dmaCfg);
    if (dma) return {dmaCfg, 1'b1};
    return {(instr ? ~trace : ~resv), ~instr, sup, 1'b0};
  endfunction

  function automatic logic traceHit(input logic [3:0] t);
    return (t[0] == 1'b0) && (t[2] == 1'b0) && (t[3] == 1'b0);
  endfunction

  function automatic logic resvHit(input logic [3:0] t);
    return (t[0] == 1'b0) && (t[2] == 1'b1) && (t[3] == 1'b0);
  endfunction

endpackage

// File: rtl/showQueue.sv
module showQueue #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : PW'(p + 1'b1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  assign rdData = mem[rdPtr];
  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !push) else $error("queue push while full"); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !pop) else $error("queue pop while empty"); // R8

endmodule

// File: rtl/showCtrl.sv
module showCtrl
  import showPkg::*;
#(
  parameter int BURST_BEATS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        coreReq,
  input  logic        coreBurst,
  input  logic        qFull,
  input  logic        qEmpty,
  input  logic        headIsData,
  output logic        coreRdy,
  output ctrlStrobe_t strobe
);
  localparam int DCW = (BURST_BEATS > 2) ? $clog2(BURST_BEATS) : 1;

  phase_t        phase, phaseNext;
  logic          curData;
  logic [DCW-1:0] dropLeft;
  logic          dropping, accept, canPop;

  assign dropping = (dropLeft != '0);
  assign coreRdy  = dropping || !qFull;
  assign accept   = coreReq && coreRdy;
  assign canPop   = !qEmpty && (phase != PH_ADDR);

  always_comb begin
    strobe          = '0;
    strobe.push     = accept && !dropping;
    strobe.pop      = canPop;
    strobe.showData = (phase == PH_ADDR) && curData;
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_ADDR: phaseNext = curData ? PH_DATA : PH_IDLE;
      default: phaseNext = canPop ? PH_ADDR : PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      curData  <= 1'b0;
      dropLeft <= '0;
    end else begin
      phase <= phaseNext;
      if (canPop) curData <= headIsData;
      if (accept && dropping)
        dropLeft <= dropLeft - 1'b1;
      else if (accept && coreBurst)
        dropLeft <= DCW'(BURST_BEATS - 1);
    end
  end

  AST_DATA_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA) |-> ($past(phase) == PH_ADDR)) else $error("data phase without address phase"); // R1
  AST_BURST_NO_QUEUE: assert property (@(posedge clk) disable iff (!rstN)
    dropping |-> !strobe.push) else $error("burst beat queued"); // R4

endmodule

// File: rtl/showDatapath.sv
module showDatapath
  import showPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int QDEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreData,
  input  logic              coreWrite,
  input  logic              coreSuper,
  input  logic              coreInstr,
  input  logic              coreTrace,
  input  logic              coreResv,
  input  logic              coreDma,
  input  logic [2:0]        dmaTypeCfg,
  output logic              qFull,
  output logic              qEmpty,
  output logic              headIsData,
  output logic [ADDR_W-1:0] extAddr,
  output logic              extAddrOe,
  output logic [DATA_W-1:0] extData,
  output logic              extDataOe,
  output logic              extStartN,
  output logic              extWrite,
  output logic [3:0]        extType,
  output logic              traceN,
  output logic              resvN
);
  localparam int EW = 1 + 4 + DATA_W + ADDR_W;
  localparam int A0 = 0;
  localparam int D0 = ADDR_W;
  localparam int T0 = ADDR_W + DATA_W;
  localparam int W0 = ADDR_W + DATA_W + 4;

  logic [EW-1:0]     inEntry, head;
  logic [ADDR_W-1:0] headAddr;
  logic [DATA_W-1:0] headData;
  logic [3:0]        headType;
  logic              headWrite;
  logic [DATA_W-1:0] heldData;
  logic              heldWrite;

  assign inEntry = {coreWrite,
                    encType(coreDma, coreSuper, coreInstr, coreTrace, coreResv, dmaTypeCfg),
                    coreData, coreAddr};

  showQueue #(.WIDTH(EW), .DEPTH(QDEPTH)) uQueue (
    .clk    (clk),
    .rstN   (rstN),
    .push   (strobe.push),
    .pop    (strobe.pop),
    .wrData (inEntry),
    .rdData (head),
    .full   (qFull),
    .empty  (qEmpty)
  );

  assign headAddr   = head[A0 +: ADDR_W];
  assign headData   = head[D0 +: DATA_W];
  assign headType   = head[T0 +: 4];
  assign headWrite  = head[W0];
  assign headIsData = headType[2];

  // Address phase registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extAddrOe <= 1'b0;
      extAddr   <= '0;
      extType   <= '0;
      extStartN <= 1'b1;
      traceN    <= 1'b1;
      resvN     <= 1'b1;
      heldData  <= '0;
      heldWrite <= 1'b0;
    end else begin
      extAddrOe <= strobe.pop;
      extStartN <= !strobe.pop;
      if (strobe.pop) begin
        extAddr   <= headAddr;
        extType   <= headType;
        traceN    <= !traceHit(headType);
        resvN     <= !resvHit(headType);
        heldData  <= headData;
        heldWrite <= headWrite;
      end else begin
        extAddr <= '0;
        extType <= '0;
        traceN  <= 1'b1;
        resvN   <= 1'b1;
      end
    end
  end

  // Data phase and direction registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extDataOe <= 1'b0;
      extData   <= '0;
      extWrite  <= 1'b0;
    end else begin
      extDataOe <= strobe.showData;
      extData   <= strobe.showData ? heldData : '0;
      if (strobe.pop)           extWrite <= headWrite;
      else if (strobe.showData) extWrite <= heldWrite;
      else                      extWrite <= 1'b0;
    end
  end

  AST_ADDR_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN)
    extAddrOe |=> !extAddrOe) else $error("address held too long"); // R2
  AST_DATA_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN)
    extDataOe |=> !extDataOe) else $error("data held too long"); // R3
  AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    extDataOe |-> ($past(extAddrOe) && $past(extType[2]))) else $error("stray data phase"); // R1
  AST_TRACE_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    !traceN |-> (extAddrOe && extType[3:2] == 2'b00 && !extType[0])) else $error("bad trace pin"); // R7
  AST_RESV_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    !resvN |-> (extAddrOe && extType[3:2] == 2'b01 && !extType[0])) else $error("bad resv pin"); // R7
  AST_DMA_PINS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    extType[0] |-> (traceN && resvN)) else $error("indicator on DMA"); // R7
  AST_IDLE_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    !extAddrOe |-> (extStartN && extAddr == '0 && extType == '0)) else $error("idle not at rest"); // R9
  AST_IDLE_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !extDataOe |-> (extData == '0)) else $error("idle data not zero"); // R9

endmodule

// File: rtl/showcyc_mirror.sv
module showcyc_mirror
  import showPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int QDEPTH      = 2,
  parameter int BURST_BEATS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreReq,
  output logic              coreRdy,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreData,
  input  logic              coreWrite,
  input  logic              coreBurst,
  input  logic              coreSuper,
  input  logic              coreInstr,
  input  logic              coreTrace,
  input  logic              coreResv,
  input  logic              coreDma,
  input  logic [2:0]        dmaTypeCfg,
  output logic [ADDR_W-1:0] extAddr,
  output logic              extAddrOe,
  output logic [DATA_W-1:0] extData,
  output logic              extDataOe,
  output logic              extStartN,
  output logic              extWrite,
  output logic [3:0]        extType,
  output logic              traceN,
  output logic              resvN
);
  ctrlStrobe_t strobe;
  logic        qFull, qEmpty, headIsData;

  showCtrl #(.BURST_BEATS(BURST_BEATS)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .coreReq    (coreReq),
    .coreBurst  (coreBurst),
    .qFull      (qFull),
    .qEmpty     (qEmpty),
    .headIsData (headIsData),
    .coreRdy    (coreRdy),
    .strobe     (strobe)
  );

  showDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .QDEPTH(QDEPTH)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .coreAddr   (coreAddr),
    .coreData   (coreData),
    .coreWrite  (coreWrite),
    .coreSuper  (coreSuper),
    .coreInstr  (coreInstr),
    .coreTrace  (coreTrace),
    .coreResv   (coreResv),
    .coreDma    (coreDma),
    .dmaTypeCfg (dmaTypeCfg),
    .qFull      (qFull),
    .qEmpty     (qEmpty),
    .headIsData (headIsData),
    .extAddr    (extAddr),
    .extAddrOe  (extAddrOe),
    .extData    (extData),
    .extDataOe  (extDataOe),
    .extStartN  (extStartN),
    .extWrite   (extWrite),
    .extType    (extType),
    .traceN     (traceN),
    .resvN      (resvN)
  );

endmodule

// File: tb/showcyc_mirror_test.sv
`timescale 1ns/1ps
module showcyc_mirror_test;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BEATS = 4;

  typedef struct packed {
    logic dma, sup, instr, trc, rsv, wr;
    logic [2:0] cfg;
    logic [3:0] expType;
    logic expTrN, expRsN, expData;
  } vec_t;

  // dma sup instr trc rsv wr cfg | type trN rsN hasData
  localparam vec_t VECS [8] = '{
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,3'b000, 4'b0010,1'b0,1'b1,1'b0},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,3'b000, 4'b1010,1'b1,1'b1,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,3'b000, 4'b0100,1'b1,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000, 4'b1100,1'b1,1'b1,1'b1},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,3'b000, 4'b0000,1'b0,1'b1,1'b0},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,3'b000, 4'b1110,1'b1,1'b1,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000, 4'b0001,1'b1,1'b1,1'b0},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,3'b010, 4'b0101,1'b1,1'b1,1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic coreReq = 1'b0, coreWrite = 1'b0, coreBurst = 1'b0, coreSuper = 1'b0;
  logic coreInstr = 1'b0, coreTrace = 1'b0, coreResv = 1'b0, coreDma = 1'b0;
  logic [AW-1:0] coreAddr = '0;
  logic [DW-1:0] coreData = '0;
  logic [2:0] dmaTypeCfg = '0;
  logic coreRdy, extAddrOe, extDataOe, extStartN, extWrite, traceN, resvN;
  logic [AW-1:0] extAddr;
  logic [DW-1:0] extData;
  logic [3:0] extType;

  int nChecks = 0;
  int nFails = 0;
  logic [AW-1:0] seenAddr [16];
  logic [DW-1:0] seenData [16];
  int seenA = 0;
  int seenD = 0;

  always #2.5 clk = ~clk;

  showcyc_mirror #(.ADDR_W(AW), .DATA_W(DW), .QDEPTH(2), .BURST_BEATS(BEATS)) uut (.*);

  always @(negedge clk) begin
    if (rstN && extAddrOe && seenA < 16) begin seenAddr[seenA] = extAddr; seenA = seenA + 1; end
    if (rstN && extDataOe && seenD < 16) begin seenData[seenD] = extData; seenD = seenD + 1; end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    chk(req, {extAddrOe, extDataOe, extStartN, traceN, resvN, extWrite}, 6'b001110);
    chk(req, {extAddr, extData}, '0);
    chk(req, extType, 4'h0);
  endtask

  task automatic setReq(input vec_t v, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic burst);
    coreReq = 1'b1; coreAddr = a; coreData = d; coreBurst = burst;
    coreDma = v.dma; coreSuper = v.sup; coreInstr = v.instr; coreTrace = v.trc;
    coreResv = v.rsv; coreWrite = v.wr; dmaTypeCfg = v.cfg;
  endtask

  task automatic dropReq();
    coreReq = 1'b0; coreBurst = 1'b0;
  endtask

  task automatic finish();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    checkIdle("R10 reset");
    chk("R10 rdy in reset", coreRdy, 1'b1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle("R9 idle after reset");

    // Vector walk: R2 R6 R7 R1 R3 R5
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = 32'h1000_0000 + 32'(i * 16);
      d = 32'hC0DE_0000 + 32'(i);
      setReq(VECS[i], a, d, 1'b0);
      @(posedge clk);               // accept edge k
      @(negedge clk); dropReq();
      @(posedge clk);               // edge k+1
      @(negedge clk);
      chk($sformatf("R2 v%0d addr phase", i), {extAddrOe, extStartN, extDataOe}, 3'b100);
      chk($sformatf("R2 v%0d addr", i), extAddr, a);
      chk($sformatf("R6 v%0d type", i), extType, VECS[i].expType);
      chk($sformatf("R7 v%0d pins", i), {traceN, resvN}, {VECS[i].expTrN, VECS[i].expRsN});
      chk($sformatf("R5 v%0d dir", i), extWrite, VECS[i].wr);
      @(negedge clk);
      chk($sformatf("R1 v%0d data phase", i), {extDataOe, extAddrOe, extStartN}, {VECS[i].expData, 2'b01});
      if (VECS[i].expData) begin
        chk($sformatf("R5 v%0d data", i), extData, d);
        chk($sformatf("R5 v%0d dir in data", i), extWrite, VECS[i].wr);
      end
      @(negedge clk);
      checkIdle($sformatf("R3 v%0d ends", i));
      repeat (2) @(negedge clk);
    end

    // R4: burst, only first beat shown
    seenA = 0; seenD = 0;
    setReq(VECS[3], 32'h2000_0000, 32'hAAAA_0001, 1'b1);
    @(posedge clk);
    for (int b = 1; b < BEATS; b++) begin
      @(negedge clk);
      setReq(VECS[3], 32'h2000_0000 + 32'(b * 4), 32'hBAD0_0000 + 32'(b), 1'b0);
      chk("R4 rdy on later beat", coreRdy, 1'b1);
      @(posedge clk);
    end
    @(negedge clk);
    setReq(VECS[5], 32'h3000_0000, 32'h5555_0002, 1'b0);
    @(posedge clk);
    @(negedge clk); dropReq();
    repeat (10) @(negedge clk);
    chk("R4 show count", seenA, 2);
    chk("R4 first addr", seenAddr[0], 32'h2000_0000);
    chk("R4 next addr", seenAddr[1], 32'h3000_0000);
    chk("R4 data count", seenD, 2);
    chk("R4 first beat data", seenData[0], 32'hAAAA_0001);
    chk("R4 following data", seenData[1], 32'h5555_0002);

    // R8: stream of data accesses, stall and order
    begin
      int stalls;
      stalls = 0;
      seenA = 0; seenD = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        setReq(VECS[3], 32'h4000_0000 + 32'(i), 32'h7700_0000 + 32'(i), 1'b0);
        while (!coreRdy) begin stalls++; @(negedge clk); end
        @(posedge clk);
      end
      @(negedge clk); dropReq();
      repeat (20) @(negedge clk);
      chk("R8 stalled when full", (stalls > 0), 1'b1);
      chk("R8 all shown", seenA, 5);
      for (int i = 0; i < 5; i++) begin
        chk($sformatf("R8 order addr %0d", i), seenAddr[i], 32'h4000_0000 + 32'(i));
        chk($sformatf("R8 order data %0d", i), seenData[i], 32'h7700_0000 + 32'(i));
      end
    end

    // R10: reset during an address phase drops the access
    seenA = 0;
    setReq(VECS[2], 32'h5000_0000, 32'h1234_5678, 1'b0);
    @(posedge clk);
    @(negedge clk);
    setReq(VECS[2], 32'h5000_0010, 32'h1234_0000, 1'b0);
    @(posedge clk);
    @(negedge clk); dropReq();
    chk("R10 addr phase before reset", extAddrOe, 1'b1);
    rstN = 1'b0;
    #1;
    checkIdle("R10 reset mid-cycle");
    @(negedge clk); rstN = 1'b1;
    seenA = 0; seenD = 0;
    repeat (6) @(negedge clk);
    chk("R10 queue cleared", seenA, 0);
    chk("R10 rdy after reset", coreRdy, 1'b1);
    checkIdle("R9 idle end");

    finish();
  end
endmodule